// File: doc/BRIEF.md
# Masked Real-Time Alarm Comparator

This block holds the alarm settings of a real-time clock: one byte each for seconds, minutes, hours and day of month. An external time-of-day counter supplies the current time as BCD fields, together with a once-per-second tick. On each rising edge of the tick the block compares the alarm against the current time. If they match, and the alarm is enabled, it raises a one-cycle interrupt pulse.

Bit 7 of each alarm byte is a mask bit that takes the field out of the comparison. The masks are read as a cumulative pattern that sets the repeat rate: monthly, daily, hourly, once a minute or once a second. A byte-wide register port accepts writes and checks each alarm value for its range. An out-of-range write leaves the old byte in place. Reads return the stored bytes exactly as they were written, mask bits included.

Register map (3-bit address): 0 seconds alarm, 1 minutes alarm, 2 hours alarm, 3 date alarm, 4 control (bit 0 = alarm enable). Addresses 5 to 7 read as 0x00 and ignore writes.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset the seconds, minutes and hours alarm bytes read 0x00, the date alarm byte reads 0x01, the control byte reads 0x00 and alarm_irq_o is low.
- R2: A read of address 0 to 3 returns the whole stored byte, including bit 7 and any unused bits. Address 4 returns {7'b0, enable}, whatever was written to bits 7:1. Addresses 5 to 7 return 0x00.
- R3: For the seconds alarm (address 0) and the minutes alarm (address 1), the value is computed as bits[6:4]*10 + bits[3:0]. A write is stored only if this value is at most 59; otherwise the byte is unchanged.
- R4: For the hours alarm (address 2), the value is computed as bits[5:4]*10 + bits[3:0]. A write is stored only if this value is at most 23.
- R5: For the date alarm (address 3), the value is computed as bit[4]*10 + bits[3:0]. A write is stored only if this value is non-zero. Bits 7:5 do not enter this check.
- R6: With all four mask bits clear, a match needs all four fields to be equal: seconds on bits[6:0], minutes on bits[6:0], hours on bits[5:0] and date on bits[5:0], each compared against the current-time inputs.
- R7: With only the date mask set, hours, minutes and seconds must match (daily). With date and hours masked, minutes and seconds must match (hourly). With date, hours and minutes masked, only seconds must match (once a minute).
- R8: With all four masks set, or with any other mask combination not named in R6 or R7, every tick counts as a match.
- R9: On a rising edge of tick_i that is a match, alarm_irq_o is high for exactly the one following cycle. A tick held high for several cycles gives only one pulse.
- R10: No interrupt is raised while the enable bit (bit 0 of address 4) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational from the address) |
| tick_i | input | 1 | One-second tick from the time counter |
| now_sec_i | input | 7 | Current seconds, BCD |
| now_min_i | input | 7 | Current minutes, BCD |
| now_hour_i | input | 6 | Current hours, BCD |
| now_date_i | input | 6 | Current day of month, BCD |
| alarm_irq_o | output | 1 | Alarm interrupt pulse |

## Verification
The assertions check three things on every cycle: that a rejected write leaves the alarm byte unchanged, that the interrupt never lasts longer than one cycle and always follows a tick edge while the alarm is enabled, and that a fully masked or unlisted mask pattern always matches. Other behaviour only shows up in the bench's scenarios. This includes choosing the correct repeat rate for each cumulative mask pattern, and the exact field comparisons in the monthly, daily, hourly and minute modes. It also includes the readback of the mask bits and the unused bits, and the single pulse from a long tick. A behavioural model in the bench follows every write and tick and checks readback and the interrupt on every clock.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_SEC  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MIN  = 3'd1;
  localparam logic [ADDR_W-1:0] A_HOUR = 3'd2;
  localparam logic [ADDR_W-1:0] A_DATE = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd4;

  typedef struct packed {
    logic [DATA_W-1:0] date;
    logic [DATA_W-1:0] hour;
    logic [DATA_W-1:0] min;
    logic [DATA_W-1:0] sec;
  } alarm_set_t;

  // two BCD digits to binary, wide enough for non-decimal digit codes
  function automatic logic [7:0] bcd_to_bin(input logic [3:0] hi, input logic [3:0] lo);
    return ({4'b0, hi} * 8'd10) + {4'b0, lo};
  endfunction
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import alarm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output alarm_set_t        alarm_o,
  output logic              en_o
);
  alarm_set_t alarm_q;
  logic       en_q;
  logic       sec_ok, min_ok, hour_ok, date_ok;

  always_comb begin
    sec_ok  = bcd_to_bin({1'b0, wdata_i[6:4]}, wdata_i[3:0]) <= 8'd59;
    min_ok  = sec_ok;
    hour_ok = bcd_to_bin({2'b0, wdata_i[5:4]}, wdata_i[3:0]) <= 8'd23;
    date_ok = bcd_to_bin({3'b0, wdata_i[4]}, wdata_i[3:0]) != 8'd0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_q.sec  <= 8'h00;
      alarm_q.min  <= 8'h00;
      alarm_q.hour <= 8'h00;
      alarm_q.date <= 8'h01;
      en_q         <= 1'b0;
    end else if (we_i) begin
      unique case (addr_i)
        A_SEC:   if (sec_ok)  alarm_q.sec  <= wdata_i;
        A_MIN:   if (min_ok)  alarm_q.min  <= wdata_i;
        A_HOUR:  if (hour_ok) alarm_q.hour <= wdata_i;
        A_DATE:  if (date_ok) alarm_q.date <= wdata_i;
        A_CTRL:  en_q <= wdata_i[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (addr_i)
      A_SEC:   rdata_o = alarm_q.sec;
      A_MIN:   rdata_o = alarm_q.min;
      A_HOUR:  rdata_o = alarm_q.hour;
      A_DATE:  rdata_o = alarm_q.date;
      A_CTRL:  rdata_o = {{(DATA_W-1){1'b0}}, en_q};
      default: rdata_o = '0;
    endcase
  end

  assign alarm_o = alarm_q;
  assign en_o    = en_q;

  AST_SEC_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_SEC && !sec_ok) |=> $stable(alarm_q.sec)); // R3
  AST_HOUR_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_HOUR && !hour_ok) |=> $stable(alarm_q.hour)); // R4
  AST_DATE_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_DATE && !date_ok) |=> $stable(alarm_q.date)); // R5
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
  import alarm_pkg::*;
#(
  parameter int unsigned SEC_W  = 7,
  parameter int unsigned MIN_W  = 7,
  parameter int unsigned HOUR_W = 6,
  parameter int unsigned DATE_W = 6
) (
  input  alarm_set_t        alarm_i,
  input  logic [SEC_W-1:0]  now_sec_i,
  input  logic [MIN_W-1:0]  now_min_i,
  input  logic [HOUR_W-1:0] now_hour_i,
  input  logic [DATE_W-1:0] now_date_i,
  output logic [3:0]        mask_o,
  output logic              hit_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic sec_eq, min_eq, hour_eq, date_eq;

  assign sec_eq  = alarm_i.sec[SEC_W-1:0]   == now_sec_i;
  assign min_eq  = alarm_i.min[MIN_W-1:0]   == now_min_i;
  assign hour_eq = alarm_i.hour[HOUR_W-1:0] == now_hour_i;
  assign date_eq = alarm_i.date[DATE_W-1:0] == now_date_i;

  // {date, hour, min, sec} mask bits
  assign mask_o = {alarm_i.date[MSB], alarm_i.hour[MSB], alarm_i.min[MSB], alarm_i.sec[MSB]};

  always_comb begin
    unique case (mask_o)
      4'b0000: hit_o = date_eq & hour_eq & min_eq & sec_eq;
      4'b1000: hit_o = hour_eq & min_eq & sec_eq;
      4'b1100: hit_o = min_eq & sec_eq;
      4'b1110: hit_o = sec_eq;
      default: hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/alarm_pulse.sv
module alarm_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hit_i,
  input  logic en_i,
  output logic irq_o
);
  logic tick_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      tick_q <= tick_i;
      irq_q  <= tick_i & ~tick_q & hit_i & en_i;
    end
  end

  assign irq_o = irq_q;

  AST_IRQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R9
  AST_IRQ_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(tick_i)); // R9
  AST_IRQ_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(en_i)); // R10
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import alarm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic [2:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       tick_i,
  input  logic [6:0] now_sec_i,
  input  logic [6:0] now_min_i,
  input  logic [5:0] now_hour_i,
  input  logic [5:0] now_date_i,
  output logic       alarm_irq_o
);
  alarm_set_t alarm;
  logic       en, hit;
  logic [3:0] mask;

  alarm_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .alarm_o (alarm),
    .en_o    (en)
  );

  alarm_cmp #(.SEC_W(7), .MIN_W(7), .HOUR_W(6), .DATE_W(6)) u_cmp (
    .alarm_i    (alarm),
    .now_sec_i  (now_sec_i),
    .now_min_i  (now_min_i),
    .now_hour_i (now_hour_i),
    .now_date_i (now_date_i),
    .mask_o     (mask),
    .hit_o      (hit)
  );

  alarm_pulse u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .hit_i  (hit),
    .en_i   (en),
    .irq_o  (alarm_irq_o)
  );

  AST_FREE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mask inside {4'b0000, 4'b1000, 4'b1100, 4'b1110}) |-> hit); // R8
endmodule

// File: tb/tb_rtc_alarm_match.sv
`timescale 1ns/1ps
module tb_rtc_alarm_match;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       tick = 1'b0;
  logic [6:0] nsec = 7'h00, nmin = 7'h00;
  logic [5:0] nhour = 6'h00, ndate = 6'h01;
  logic       irq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_alarm_match dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tick_i(tick),
    .now_sec_i(nsec), .now_min_i(nmin), .now_hour_i(nhour),
    .now_date_i(ndate), .alarm_irq_o(irq)
  );

  // behavioural reference model
  int m_reg[4];
  int m_en, m_irq, m_tick_q;

  function automatic int dec2(int v, int hi_mask);
    return ((v >> 4) & hi_mask) * 10 + (v & 15);
  endfunction

  function automatic bit m_match();
    bit ds, dm, dh, dd;
    int pat;
    ds = (m_reg[0] & 8'h7F) == nsec;
    dm = (m_reg[1] & 8'h7F) == nmin;
    dh = (m_reg[2] & 8'h3F) == nhour;
    dd = (m_reg[3] & 8'h3F) == ndate;
    pat = ((m_reg[3] >> 7) << 3) | ((m_reg[2] >> 7) << 2) | ((m_reg[1] >> 7) << 1) | (m_reg[0] >> 7);
    if (pat == 0)  return dd && dh && dm && ds;
    if (pat == 8)  return dh && dm && ds;
    if (pat == 12) return dm && ds;
    if (pat == 14) return ds;
    return 1'b1;
  endfunction

  function automatic int m_read(int a);
    if (a < 4) return m_reg[a];
    if (a == 4) return m_en;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg[0] = 0; m_reg[1] = 0; m_reg[2] = 0; m_reg[3] = 1;
      m_en = 0; m_irq = 0; m_tick_q = 0;
    end else begin
      m_irq = (tick && !m_tick_q && m_en != 0 && m_match()) ? 1 : 0;
      m_tick_q = tick;
      if (we) begin
        case (addr)
          3'd0, 3'd1: if (dec2(wdata, 7) <= 59) m_reg[addr] = wdata;
          3'd2: if (dec2(wdata, 3) <= 23) m_reg[2] = wdata;
          3'd3: if (dec2(wdata, 1) != 0) m_reg[3] = wdata;
          3'd4: m_en = wdata & 1;
          default: ;
        endcase
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      checks++;
      if (irq !== m_irq[0]) begin
        errors++;
        $display("FAIL R9 model irq actual=%0b expected=%0d", irq, m_irq);
      end
      checks++;
      if (rdata !== m_read(addr)) begin
        errors++;
        $display("FAIL R2 model rdata addr=%0d actual=%02h expected=%02h", addr, rdata, m_read(addr));
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, int exp, string tag);
    @(negedge clk); addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic set_now(logic [6:0] s, logic [6:0] m, logic [5:0] h, logic [5:0] d);
    @(negedge clk); nsec = s; nmin = m; nhour = h; ndate = d;
  endtask

  task automatic tick_chk(int len, int exp, string tag);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); #1; chk(tag, irq, exp);
    repeat (len - 1) @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1; chk("R1 irq after reset", irq, 0);
    rd(3'd0, 8'h00, "R1 sec reset");
    rd(3'd1, 8'h00, "R1 min reset");
    rd(3'd2, 8'h00, "R1 hour reset");
    rd(3'd3, 8'h01, "R1 date reset");
    rd(3'd4, 8'h00, "R1 ctrl reset");
    rd(3'd6, 8'h00, "R2 unused address");

    wr(3'd0, 8'h59); rd(3'd0, 8'h59, "R3 sec 59 accepted");
    wr(3'd0, 8'h60); rd(3'd0, 8'h59, "R3 sec 60 rejected");
    wr(3'd0, 8'h7A); rd(3'd0, 8'h59, "R3 sec 0x7A rejected");
    wr(3'd1, 8'hC5); rd(3'd1, 8'hC5, "R2 min mask and bit6 kept");
    wr(3'd1, 8'h5A); rd(3'd1, 8'hC5, "R3 min 60 rejected");
    wr(3'd2, 8'h23); rd(3'd2, 8'h23, "R4 hour 23 accepted");
    wr(3'd2, 8'h24); rd(3'd2, 8'h23, "R4 hour 24 rejected");
    wr(3'd3, 8'h00); rd(3'd3, 8'h01, "R5 date 0 rejected");
    wr(3'd3, 8'h15); rd(3'd3, 8'h15, "R5 date 15 accepted");
    wr(3'd3, 8'hA0); rd(3'd3, 8'h15, "R5 date zero low bits rejected");
    wr(3'd4, 8'hFE); rd(3'd4, 8'h00, "R2 ctrl only bit0");
    wr(3'd7, 8'hFF); rd(3'd7, 8'h00, "R2 write to unused ignored");

    // monthly alarm 15th 12:34:56
    wr(3'd0, 8'h56); wr(3'd1, 8'h34); wr(3'd2, 8'h12); wr(3'd3, 8'h15);
    set_now(7'h56, 7'h34, 6'h12, 6'h15);
    tick_chk(1, 0, "R10 disabled no irq");
    wr(3'd4, 8'h01); rd(3'd4, 8'h01, "R2 ctrl enable readback");
    tick_chk(1, 1, "R6 full match");
    set_now(7'h57, 7'h34, 6'h12, 6'h15);
    tick_chk(1, 0, "R6 seconds differ");
    set_now(7'h56, 7'h34, 6'h12, 6'h16);
    tick_chk(1, 0, "R6 date differs");

    wr(3'd3, 8'h95);
    tick_chk(1, 1, "R7 daily ignores date");
    set_now(7'h56, 7'h34, 6'h13, 6'h16);
    tick_chk(1, 0, "R7 daily hour differs");
    wr(3'd2, 8'h92);
    tick_chk(1, 1, "R7 hourly ignores hour");
    set_now(7'h56, 7'h35, 6'h13, 6'h16);
    tick_chk(1, 0, "R7 hourly minute differs");
    wr(3'd1, 8'hB4);
    tick_chk(1, 1, "R7 minute rate ignores minute");
    set_now(7'h00, 7'h35, 6'h13, 6'h16);
    tick_chk(1, 0, "R7 minute rate second differs");
    wr(3'd0, 8'hD6);
    tick_chk(1, 1, "R8 all masked");
    wr(3'd0, 8'h56); wr(3'd1, 8'h34); wr(3'd3, 8'h15);
    tick_chk(1, 1, "R8 hours-only mask every second");

    tick_chk(5, 1, "R9 long tick first pulse");
    @(negedge clk); tick = 1'b1;
    repeat (3) @(negedge clk);
    #1; chk("R9 held tick no repeat", irq, 0);
    tick = 1'b0;
    @(negedge clk);

    wr(3'd4, 8'h00);
    tick_chk(1, 0, "R10 disabled again");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule